// File: doc/BRIEF.md
# Dataway Slave Command Decoder with Look-At-Me

This block is the slave side of a crate-style parallel dataway for an eight-channel time digitizer. The controller presents a function code, a subaddress and a station-select line, then issues a first strobe and a second strobe as single-cycle pulses. The block answers with read data, a command-accepted response (X) and a conditional response (Q). It also raises a Look-At-Me service request once digitizing has finished.

Read functions capture the addressed channel's word at the first strobe. Every state change waits for the second strobe: module clear, LAM clear, LAM mask changes and the internal test start. The crate-wide initialise (Z) and clear (C) also act at the second strobe. Inhibit (I) blocks the start input of the converter.

When no channel has received a stop, the module suppresses Q and LAM, so it reads like an empty slot. X is still returned. Two configuration inputs switch each suppression off independently.

Top module: `dw_slave_decoder`

## Requirements
- R1: A read function (code 0) with station select high and subaddress 0..7 loads the read register at the first strobe. Bits [10:0] take that channel's data word and bit 11 takes its overflow flag. The value appears on `r_data` from the next cycle. A first strobe with station select high but no valid read loads zero. Without a first strobe, `r_data` holds its value.
- R2: Function code 2 reads exactly like code 0. With subaddress 7 it also clears the module (a one-cycle `mod_clear` pulse in the cycle after the second strobe) and clears the LAM flag.
- R3: `x_resp` is 1 exactly when station select is high, the subaddress is 0..7 and the code is one of 0, 2, 8, 9, 10, 24, 25 or 26. Any other code or subaddress gives X=0 and Q=0, and the command has no effect.
- R4: `q_resp` is 1 for an accepted code 0 or 2. It is also 1 for an accepted code 8 when the LAM flag is set and LAM is enabled. Otherwise it is 0, and it is subject to R8.
- R5: `conv_done` sets the LAM flag. A second strobe with an accepted code 9, code 10, or code 2 on subaddress 7 clears it. A second strobe with Z or C also clears it. A clear and a set in the same cycle leave the flag clear.
- R6: `lam_req` equals flag AND enable AND NOT station select AND NOT LAM suppression.
- R7: An accepted code 26 at the second strobe enables LAM. An accepted code 24 at the second strobe disables it, and so does Z at the second strobe. Disabling wins over enabling. After reset LAM is disabled.
- R8: When every `chan_hit` bit is 0, Q is forced to 0 unless `q_sup_off` is 1. Under the same condition, LAM is forced to 0 unless `lam_sup_off` is 1.
- R9: An accepted code 25 at the second strobe produces a one-cycle `test_start` pulse in the next cycle.
- R10: Z or C together with the second strobe produces a `mod_clear` pulse in the next cycle. An accepted code 9 at the second strobe does the same. `start_inhibit` follows the crate inhibit line.
- R11: Without the second strobe, codes 2, 9, 10, 24, 25 and 26 and the Z and C lines change no state and produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_f | input | 5 | Function code |
| cmd_a | input | 4 | Subaddress |
| stn_sel | input | 1 | Station select for this module |
| strobe1 | input | 1 | First strobe pulse |
| strobe2 | input | 1 | Second strobe pulse |
| crate_z | input | 1 | Crate initialise |
| crate_c | input | 1 | Crate clear |
| crate_i | input | 1 | Crate inhibit |
| chan_data | input | 88 | Packed channel words, channel k at [11k+10:11k] |
| chan_ovf | input | 8 | Overflow flag per channel |
| chan_hit | input | 8 | Stop-received flag per channel |
| conv_done | input | 1 | End-of-digitizing event pulse |
| q_sup_off | input | 1 | 1 disables Q suppression |
| lam_sup_off | input | 1 | 1 disables LAM suppression |
| r_data | output | 12 | Read register: overflow at bit 11, data at [10:0] |
| x_resp | output | 1 | Command accepted |
| q_resp | output | 1 | Conditional response |
| lam_req | output | 1 | Look-At-Me request |
| mod_clear | output | 1 | Module clear pulse |
| test_start | output | 1 | Internal test conversion start pulse |
| start_inhibit | output | 1 | Blocks the converter start |

## Verification
The hardest situation to reach is a conflict in a single cycle. A set and a clear of the LAM flag can coincide, or a disable and an enable of the mask can coincide, while suppression and the station-select mask hide the result from `lam_req`. The directed part of the stimulus builds these collisions on purpose. It then reads the flag back through code 8 with station select high, with all hits present and later with suppression switched off. A long random sweep follows with rare strobes, Z and C, and a reference model is compared in every cycle.

// File: rtl/dw_cmd_pkg.sv
package dw_cmd_pkg;

  typedef struct packed {
    logic valid;
    logic is_read;
    logic test_lam;
    logic clr_mod;
    logic clr_lam;
    logic lam_off;
    logic lam_on;
    logic test;
  } cmd_t;

  // Decode one command; in_rng says the subaddress names a channel,
  // a_last says it names the highest channel.
  function automatic cmd_t decode_cmd(input logic [4:0] f, input logic in_rng,
                                      input logic a_last);
    cmd_t c;
    c = '0;
    case (f)
      5'd0:  c.is_read  = 1'b1;
      5'd2:  begin c.is_read = 1'b1; c.clr_mod = a_last; c.clr_lam = a_last; end
      5'd8:  c.test_lam = 1'b1;
      5'd9:  begin c.clr_mod = 1'b1; c.clr_lam = 1'b1; end
      5'd10: c.clr_lam  = 1'b1;
      5'd24: c.lam_off  = 1'b1;
      5'd25: c.test     = 1'b1;
      5'd26: c.lam_on   = 1'b1;
      default: c = '0;
    endcase
    c.valid = in_rng & (|{c.is_read, c.test_lam, c.clr_lam, c.lam_off, c.test, c.lam_on});
    if (!in_rng) c = '0;
    return c;
  endfunction

  // Suppression applies when no channel saw a stop and the override is off.
  function automatic logic suppressed(input logic any_hit, input logic override_off);
    return ~any_hit & ~override_off;
  endfunction

endpackage

// File: rtl/dw_cmd_decode.sv
module dw_cmd_decode
  import dw_cmd_pkg::*;
#(
  parameter int NCH = 8,
  parameter int AW  = 4,
  localparam int SELW = $clog2(NCH)
) (
  input  logic [4:0]      f,
  input  logic [AW-1:0]   a,
  output cmd_t            cmd,
  output logic [SELW-1:0] sel
);
  localparam logic [AW-1:0] A_LAST = AW'(NCH - 1);

  logic in_rng;
  assign in_rng = (a <= A_LAST);
  assign sel    = a[SELW-1:0];
  assign cmd    = decode_cmd(f, in_rng, a == A_LAST);
endmodule

// File: rtl/dw_lam_ctrl.sv
module dw_lam_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic en_on,
  input  logic en_off,
  output logic flag,
  output logic en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      en   <= 1'b0;
    end else begin
      if (clr_evt)      flag <= 1'b0;
      else if (set_evt) flag <= 1'b1;
      if (en_off)       en <= 1'b0;
      else if (en_on)   en <= 1'b1;
    end
  end
endmodule

// File: rtl/dw_read_reg.sv
module dw_read_reg #(
  parameter int NCH = 8,
  parameter int DW  = 11,
  localparam int SELW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            load_word,
  input  logic [SELW-1:0] sel,
  input  logic [NCH*DW-1:0] chan_data,
  input  logic [NCH-1:0]  chan_ovf,
  output logic [DW:0]     r_data
);
  logic [DW-1:0] words [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign words[g] = chan_data[g*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       r_data <= '0;
    else if (capture) r_data <= load_word ? {chan_ovf[sel], words[sel]} : '0;
  end
endmodule

// File: rtl/dw_slave_decoder.sv
module dw_slave_decoder
  import dw_cmd_pkg::*;
#(
  parameter int NCH = 8,
  parameter int DW  = 11,
  parameter int AW  = 4,
  localparam int SELW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        cmd_f,
  input  logic [AW-1:0]     cmd_a,
  input  logic              stn_sel,
  input  logic              strobe1,
  input  logic              strobe2,
  input  logic              crate_z,
  input  logic              crate_c,
  input  logic              crate_i,
  input  logic [NCH*DW-1:0] chan_data,
  input  logic [NCH-1:0]    chan_ovf,
  input  logic [NCH-1:0]    chan_hit,
  input  logic              conv_done,
  input  logic              q_sup_off,
  input  logic              lam_sup_off,
  output logic [DW:0]       r_data,
  output logic              x_resp,
  output logic              q_resp,
  output logic              lam_req,
  output logic              mod_clear,
  output logic              test_start,
  output logic              start_inhibit
);
  cmd_t            cmd;
  logic [SELW-1:0] sel;
  logic            addressed, act, crate_clr;
  logic            clr_mod_evt, clr_lam_evt, en_on, en_off, test_evt;
  logic            lam_flag, lam_en, q_sup, l_sup;

  dw_cmd_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .f(cmd_f), .a(cmd_a), .cmd(cmd), .sel(sel)
  );

  // Named internal events
  assign addressed   = stn_sel & cmd.valid;
  assign act         = addressed & strobe2;
  assign crate_clr   = strobe2 & (crate_z | crate_c);
  assign clr_mod_evt = (act & cmd.clr_mod) | crate_clr;
  assign clr_lam_evt = (act & cmd.clr_lam) | crate_clr;
  assign en_off      = (act & cmd.lam_off) | (strobe2 & crate_z);
  assign en_on       = act & cmd.lam_on;
  assign test_evt    = act & cmd.test;
  assign q_sup       = suppressed(|chan_hit, q_sup_off);
  assign l_sup       = suppressed(|chan_hit, lam_sup_off);

  dw_lam_ctrl u_lam (
    .clk(clk), .rst_n(rst_n), .set_evt(conv_done), .clr_evt(clr_lam_evt),
    .en_on(en_on), .en_off(en_off), .flag(lam_flag), .en(lam_en)
  );

  dw_read_reg #(.NCH(NCH), .DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .capture(strobe1 & stn_sel),
    .load_word(addressed & cmd.is_read), .sel(sel),
    .chan_data(chan_data), .chan_ovf(chan_ovf), .r_data(r_data)
  );

  assign x_resp        = addressed;
  assign q_resp        = addressed & ~q_sup &
                         (cmd.is_read | (cmd.test_lam & lam_flag & lam_en));
  assign lam_req       = lam_flag & lam_en & ~stn_sel & ~l_sup;
  assign start_inhibit = crate_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_clear  <= 1'b0;
      test_start <= 1'b0;
    end else begin
      mod_clear  <= clr_mod_evt;
      test_start <= test_evt;
    end
  end
endmodule

// File: rtl/dw_slave_decoder_chk.sv
module dw_slave_decoder_chk #(
  parameter int NCH = 8,
  parameter int AW  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [4:0]    cmd_f,
  input logic [AW-1:0] cmd_a,
  input logic          stn_sel,
  input logic          strobe2,
  input logic [NCH-1:0] chan_hit,
  input logic          lam_sup_off,
  input logic          x_resp,
  input logic          q_resp,
  input logic          lam_req,
  input logic          mod_clear,
  input logic          test_start,
  input logic          lam_en
);
  localparam logic [AW-1:0] A_LAST = AW'(NCH - 1);

  assert_x_needs_station_R3: assert property (@(posedge clk) disable iff (!rst_n)
    x_resp |-> stn_sel);
  assert_q_implies_x_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_resp |-> x_resp);
  assert_lam_masked_by_n_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stn_sel |-> !lam_req);
  assert_lam_suppressed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_hit == '0 && !lam_sup_off) |-> !lam_req);
  assert_clear_after_s2_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mod_clear |-> $past(strobe2));
  assert_test_after_f25_R9: assert property (@(posedge clk) disable iff (!rst_n)
    test_start |-> $past(strobe2 && stn_sel && cmd_f == 5'd25 && cmd_a <= A_LAST));
  assert_enable_from_f26_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lam_en) |-> $past(strobe2 && stn_sel && cmd_f == 5'd26 && cmd_a <= A_LAST));
endmodule

bind dw_slave_decoder dw_slave_decoder_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_f(cmd_f), .cmd_a(cmd_a), .stn_sel(stn_sel),
  .strobe2(strobe2), .chan_hit(chan_hit), .lam_sup_off(lam_sup_off),
  .x_resp(x_resp), .q_resp(q_resp), .lam_req(lam_req), .mod_clear(mod_clear),
  .test_start(test_start), .lam_en(lam_en)
);

// File: tb/dw_slave_decoder_tb.sv
module dw_slave_decoder_tb;
  logic clk = 0, rst_n = 0;
  logic [4:0] f = 0;
  logic [3:0] a = 0;
  logic n = 0, s1 = 0, s2 = 0, z = 0, c = 0, i_n = 0, done = 0, qoff = 0, loff = 0;
  logic [7:0] hit = 8'hFF, ovf = 0;
  logic [87:0] data;
  logic [11:0] r_data;
  logic x, q, lam, mclr, tst, inh;
  int tests = 0, fails = 0, cyc = 0;

  // reference model state
  logic m_flag = 0, m_en = 0, m_clr = 0, m_tst = 0;
  logic [11:0] m_rd = 0;
  logic [10:0] bd [8];

  always #4 clk = ~clk;

  dw_slave_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_f(f), .cmd_a(a), .stn_sel(n), .strobe1(s1),
    .strobe2(s2), .crate_z(z), .crate_c(c), .crate_i(i_n), .chan_data(data),
    .chan_ovf(ovf), .chan_hit(hit), .conv_done(done), .q_sup_off(qoff),
    .lam_sup_off(loff), .r_data(r_data), .x_resp(x), .q_resp(q), .lam_req(lam),
    .mod_clear(mclr), .test_start(tst), .start_inhibit(inh)
  );

  always_comb for (int k = 0; k < 8; k++) data[k*11 +: 11] = bd[k];

  function automatic bit known(int fc);
    return fc == 0 || fc == 2 || fc == 8 || fc == 9 || fc == 10 ||
           fc == 24 || fc == 25 || fc == 26;
  endfunction
  function automatic bit ok();
    return n && a < 8 && known(int'(f));
  endfunction
  function automatic bit empty_mod();
    return hit == 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag <= 0; m_en <= 0; m_clr <= 0; m_tst <= 0; m_rd <= 0;
    end else begin
      automatic int fc = int'(f);
      automatic bit all = s2 && (z || c);
      automatic bit go = s2 && ok();
      if (all || (go && (fc == 9 || fc == 10 || (fc == 2 && a == 7)))) m_flag <= 0;
      else if (done) m_flag <= 1;
      if ((s2 && z) || (go && fc == 24)) m_en <= 0;
      else if (go && fc == 26) m_en <= 1;
      m_clr <= all || (go && (fc == 9 || (fc == 2 && a == 7)));
      m_tst <= go && fc == 25;
      if (s1 && n) m_rd <= (ok() && (fc == 0 || fc == 2)) ? {ovf[a[2:0]], bd[a[2:0]]} : 12'h000;
    end
  end

  task automatic cmp(string nm, string req, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", req, nm, cyc, act, exp);
    end
  endtask

  // check all outputs against the model, then advance one clock
  task automatic tick();
    bit eq, el;
    #1;
    eq = ok() && !(empty_mod() && !qoff) &&
         (f == 0 || f == 2 || (f == 8 && m_flag && m_en));
    el = m_flag && m_en && !n && !(empty_mod() && !loff);
    tests++;
    cmp("x_resp", "R3", x, ok());
    cmp("q_resp", "R4", q, eq);
    cmp("lam_req", "R6", lam, el);
    cmp("r_data", "R1", r_data, m_rd);
    cmp("mod_clear", "R10", mclr, m_clr);
    cmp("test_start", "R9", tst, m_tst);
    cmp("start_inhibit", "R10", inh, i_n);
    @(posedge clk); @(negedge clk);
    cyc++;
  endtask

  task automatic cmd(int fc, int ac, bit st1, bit st2);
    f = 5'(fc); a = 4'(ac); n = 1; s1 = st1; s2 = st2;
    tick();
    n = 0; s1 = 0; s2 = 0; f = 0; a = 0;
  endtask

  initial begin
    for (int k = 0; k < 8; k++) bd[k] = 11'(32'h5A3 ^ (k * 137));
    ovf = 8'b1010_0101;
    repeat (2) @(negedge clk);
    tick();                       // reset state
    rst_n = 1;
    tick();
    // R1: read every channel, word visible the cycle after the first strobe
    for (int k = 0; k < 8; k++) begin cmd(0, k, 1, 0); tick(); end
    cmd(0, 9, 1, 0); tick();      // R3: subaddress out of range reads zero
    cmd(7, 1, 1, 1); tick();      // R3: unknown code has no effect
    cmd(2, 5, 1, 1); tick();      // R2: read without clear on subaddress 5
    // R5/R7: set flag, then enable
    done = 1; tick(); done = 0;
    tick();
    cmd(26, 0, 0, 0); tick();     // R11: no strobe, no enable
    cmd(26, 0, 0, 1); tick();     // R7 enable
    cmd(8, 3, 0, 0); tick();      // R4 test LAM
    cmd(10, 0, 0, 0); tick();     // R11: clear-LAM needs second strobe
    cmd(10, 0, 0, 1); tick();     // R5 clear LAM
    done = 1; cmd(9, 2, 0, 1); tick(); // R5: clear beats set
    done = 1; tick(); done = 0;
    // R8: empty module suppression and overrides
    hit = 0; tick(); cmd(8, 0, 0, 0); cmd(0, 1, 1, 0);
    qoff = 1; cmd(8, 0, 0, 0); loff = 1; tick();
    qoff = 0; loff = 0; hit = 8'h10; tick();
    cmd(2, 7, 1, 1); tick();      // R2 read-and-clear
    cmd(25, 4, 0, 1); tick();     // R9 test start
    cmd(25, 8, 0, 1); tick();     // R3 invalid subaddress, no test
    done = 1; tick(); done = 0;
    cmd(24, 6, 0, 1); tick();     // R7 disable
    cmd(26, 6, 0, 1); done = 1; tick(); done = 0;
    s2 = 1; z = 1; tick(); s2 = 0; z = 0; tick(); // R10/R7 Z clears and disables
    cmd(26, 1, 0, 1); done = 1; tick(); done = 0;
    z = 1; c = 1; tick(); z = 0; c = 0; tick(); // R11: no strobe, no clear
    s2 = 1; c = 1; tick(); s2 = 0; c = 0; tick(); // R10 C clear
    i_n = 1; tick(); i_n = 0; tick();  // R10 inhibit
    // random sweep against the model
    for (int k = 0; k < 3000; k++) begin
      automatic int pick = $urandom_range(0, 11);
      automatic int codes[12] = '{0, 2, 8, 9, 10, 24, 25, 26, 1, 16, 31, 2};
      f = 5'(codes[pick]); a = 4'($urandom_range(0, 9));
      n = ($urandom_range(0, 3) != 0); s1 = $urandom_range(0, 1); s2 = $urandom_range(0, 2) == 0;
      z = $urandom_range(0, 30) == 0; c = $urandom_range(0, 30) == 0;
      i_n = $urandom_range(0, 1); done = $urandom_range(0, 6) == 0;
      qoff = $urandom_range(0, 3) == 0; loff = $urandom_range(0, 3) == 0;
      hit = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom);
      tick();
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule